// File: doc/BRIEF.md
# DMA Software Request Register Bank

This block lets software raise DMA requests by hand on a set of request lines. There are three kinds of request: burst, single transfer and last burst. Each kind has its own 32-bit register on a simple read/write port, and each line has one flag bit in each register. Software sets a flag by writing 1 to its bit. The flag stays set until the DMA engine returns a completion pulse for that line and kind, and is then cleared by hardware. Reading a register shows which lines still have a software request of that kind pending.

For every line and kind, the block drives a request output to the DMA engine. That output is the OR of the software flag and the matching peripheral request input, so a line can be requested from either source. All outputs are registered. A flag written at a clock edge shows on its request output right after that same edge. Peripheral inputs reach the outputs one cycle after they are sampled. Reads return data one cycle after `rd_en`.

The register offsets are byte offsets on the port: 0x20 for burst, 0x24 for single and 0x28 for last burst. Address bits [1:0] are ignored.

Top module: `dmasr_bank`

## Requirements
- R1: A write with `wdata[i]`=1 to a mapped register sets flag i of that register's kind (burst at 0x20, single at 0x24, last at 0x28). From the edge that performs the write, the matching `req_*[i]` output is 1.
- R2: A written bit of 0 leaves its flag unchanged. A write to one kind's register never changes the flags of the other two kinds.
- R3: A 1 on `done_burst[i]`, `done_single[i]` or `done_last[i]` clears flag i of that kind only, at the next edge.
- R4: If a write of 1 and a completion pulse reach the same bit in the same cycle, the write wins and the flag stays 1.
- R5: With `rd_en`=1 at an edge, `rdata` after that edge holds, in bits [15:0], the addressed kind's flags as they were before that edge. With `rd_en`=0, `rdata` is 0.
- R6: Bits 31:16 of a write are ignored, and bits 31:16 of `rdata` are always 0.
- R7: A read of any offset other than 0x20, 0x24 or 0x28 returns 0. A write to any other offset changes no flag.
- R8: After each edge, `req_*[i]` equals the flag after that edge ORed with the peripheral input `periph_*[i]` sampled at that edge.
- R9: While `rst`=1 at an edge (synchronous, active high), all flags, request outputs and `rdata` become 0.
- R10: Requests do not count or queue. Writing 1 to a flag that is already set changes nothing, and a single completion pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| periph_burst | input | 16 | Peripheral burst requests |
| periph_single | input | 16 | Peripheral single requests |
| periph_last | input | 16 | Peripheral last-burst requests |
| done_burst | input | 16 | Burst completion pulses |
| done_single | input | 16 | Single completion pulses |
| done_last | input | 16 | Last-burst completion pulses |
| req_burst | output | 16 | Burst request to the DMA engine |
| req_single | output | 16 | Single request to the DMA engine |
| req_last | output | 16 | Last-burst request to the DMA engine |

## Verification
The bench collides a write of 1 with a completion pulse on the same bit. A design that lets the completion win would drop a request that software has just raised. It writes 1 to a flag that is already set and then sends one completion pulse. A design that counts requests would keep the flag set after that pulse. It writes all-ones into bits 31:16 and to an unmapped offset. A design that decodes too loosely would show ghost flags or nonzero upper read bits. It also reads a register in the same cycle as a write to that register. A design that reads the updated flags would return the new value one cycle too early.

// File: rtl/dmasr_pkg.sv
package dmasr_pkg;
  localparam int KINDS = 3;
  typedef enum logic [1:0] {
    K_BURST  = 2'd0,
    K_SINGLE = 2'd1,
    K_LAST   = 2'd2
  } kind_e;
endpackage

// File: rtl/dmasr_decode.sv
module dmasr_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_BURST  = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_SINGLE = 8'h24,
  parameter logic [ADDR_W-1:0] OFF_LAST   = 8'h28
) (
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  output logic [dmasr_pkg::KINDS-1:0]  wr_sel,
  output logic [dmasr_pkg::KINDS-1:0]  rd_sel
);
  localparam int KN = dmasr_pkg::KINDS;
  localparam logic [ADDR_W-1:0] OFFS [KN] = '{OFF_BURST, OFF_SINGLE, OFF_LAST};

  // word-granular match, byte lanes ignored
  for (genvar k = 0; k < KN; k++) begin : g_match
    logic hit;
    assign hit       = (addr[ADDR_W-1:2] == OFFS[k][ADDR_W-1:2]);
    assign wr_sel[k] = wr_en && hit;
    assign rd_sel[k] = rd_en && hit;
  end
endmodule

// File: rtl/dmasr_flag_bank.sv
module dmasr_flag_bank #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [LINES-1:0] wbits,
  input  logic [LINES-1:0] done,
  output logic [LINES-1:0] flag,
  output logic [LINES-1:0] flag_nxt
);
  logic [LINES-1:0] set_v;

  assign set_v    = wr_hit ? wbits : '0;
  // set dominates completion on the same bit
  assign flag_nxt = (flag & ~done) | set_v;

  always_ff @(posedge clk) begin
    if (rst) flag <= '0;
    else     flag <= flag_nxt;
  end

  // R1 and R4: a written 1 is set after the edge, even with a colliding done
  assert_write_sets_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_v) & ~flag) == '0));

  // R3: done without a set clears the bit
  assert_done_clears_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag & $past(done & ~set_v)) == '0));

  // R2: untouched bits hold
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((flag ^ $past(flag)) & ~$past(set_v | done)) == '0));

  // R9: reset clears every flag
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (flag == '0));
endmodule

// File: rtl/dmasr_req_merge.sv
module dmasr_req_merge #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] flag_nxt,
  input  logic [LINES-1:0] periph,
  output logic [LINES-1:0] req
);
  always_ff @(posedge clk) begin
    if (rst) req <= '0;
    else     req <= flag_nxt | periph;
  end

  // R8: a peripheral request always reaches the output one cycle later
  assert_periph_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req & $past(periph)) == $past(periph)));
endmodule

// File: rtl/dmasr_bank.sv
module dmasr_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter logic [ADDR_W-1:0] OFF_BURST  = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_SINGLE = 8'h24,
  parameter logic [ADDR_W-1:0] OFF_LAST   = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [LINES-1:0]  periph_burst,
  input  logic [LINES-1:0]  periph_single,
  input  logic [LINES-1:0]  periph_last,
  input  logic [LINES-1:0]  done_burst,
  input  logic [LINES-1:0]  done_single,
  input  logic [LINES-1:0]  done_last,
  output logic [LINES-1:0]  req_burst,
  output logic [LINES-1:0]  req_single,
  output logic [LINES-1:0]  req_last
);
  import dmasr_pkg::*;
  localparam int KN = KINDS;

  logic [KN-1:0]    wr_sel, rd_sel;
  logic [LINES-1:0] done_k   [KN];
  logic [LINES-1:0] periph_k [KN];
  logic [LINES-1:0] flag_k   [KN];
  logic [LINES-1:0] nxt_k    [KN];
  logic [LINES-1:0] req_k    [KN];
  logic [LINES-1:0] rd_mux;

  assign done_k[K_BURST]    = done_burst;
  assign done_k[K_SINGLE]   = done_single;
  assign done_k[K_LAST]     = done_last;
  assign periph_k[K_BURST]  = periph_burst;
  assign periph_k[K_SINGLE] = periph_single;
  assign periph_k[K_LAST]   = periph_last;
  assign req_burst          = req_k[K_BURST];
  assign req_single         = req_k[K_SINGLE];
  assign req_last           = req_k[K_LAST];

  dmasr_decode #(
    .ADDR_W(ADDR_W), .OFF_BURST(OFF_BURST),
    .OFF_SINGLE(OFF_SINGLE), .OFF_LAST(OFF_LAST)
  ) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  for (genvar k = 0; k < KN; k++) begin : g_kind
    dmasr_flag_bank #(.LINES(LINES)) u_flags (
      .clk(clk), .rst(rst), .wr_hit(wr_sel[k]),
      .wbits(wdata[LINES-1:0]), .done(done_k[k]),
      .flag(flag_k[k]), .flag_nxt(nxt_k[k])
    );
    dmasr_req_merge #(.LINES(LINES)) u_merge (
      .clk(clk), .rst(rst), .flag_nxt(nxt_k[k]),
      .periph(periph_k[k]), .req(req_k[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < KN; k++)
      if (rd_sel[k]) rd_mux = flag_k[k];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{(DATA_W-LINES){1'b0}}, rd_mux};
  end

  // R7: a read that matches no register returns zero
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_sel == '0)) |=> (rdata == '0));

  // R5: no read strobe gives zero data
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

// File: tb/sim_dmasr_bank.sv
module sim_dmasr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [15:0] pb = 0, ps = 0, pl = 0, db = 0, ds = 0, dl = 0;
  logic [15:0] rb, rs, rl;

  int checks = 0, fails = 0;
  logic [15:0] mf [3];
  logic [31:0] exp_rd;
  logic [15:0] exp_rq [3];

  always #4 clk = ~clk; // 125 MHz

  dmasr_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .periph_burst(pb), .periph_single(ps), .periph_last(pl),
    .done_burst(db), .done_single(ds), .done_last(dl),
    .req_burst(rb), .req_single(rs), .req_last(rl)
  );

  function automatic int kind_of(input logic [7:0] a);
    case (a[7:2])
      6'h08:   return 0;
      6'h09:   return 1;
      6'h0a:   return 2;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, model it, compare after the edge
  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [31:0] d, input logic [15:0] xdb,
                     input logic [15:0] xds, input logic [15:0] xdl,
                     input logic [15:0] xpb, input logic [15:0] xps,
                     input logic [15:0] xpl, input string tag);
    int k;
    logic [15:0] dn [3];
    logic [15:0] pp [3];
    k = kind_of(a);
    dn[0] = xdb; dn[1] = xds; dn[2] = xdl;
    pp[0] = xpb; pp[1] = xps; pp[2] = xpl;
    exp_rd = (r && k >= 0) ? {16'h0, mf[k]} : 32'h0;
    for (int j = 0; j < 3; j++) begin
      mf[j] = mf[j] & ~dn[j];
      if (w && k == j) mf[j] = mf[j] | d[15:0];
      exp_rq[j] = mf[j] | pp[j];
    end
    wr_en = w; rd_en = r; addr = a; wdata = d;
    db = xdb; ds = xds; dl = xdl; pb = xpb; ps = xps; pl = xpl;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rdata"}, rdata, exp_rd);
    chk({tag, " req_burst"}, {16'h0, rb}, {16'h0, exp_rq[0]});
    chk({tag, " req_single"}, {16'h0, rs}, {16'h0, exp_rq[1]});
    chk({tag, " req_last"}, {16'h0, rl}, {16'h0, exp_rq[2]});
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < 3; j++) mf[j] = '0;
    chk({tag, " rdata"}, rdata, 32'h0);
    chk({tag, " req_burst"}, {16'h0, rb}, 32'h0);
    chk({tag, " req_single"}, {16'h0, rs}, 32'h0);
    chk({tag, " req_last"}, {16'h0, rl}, 32'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] addrs [6];
    void'($urandom(32'h5eed_0042));
    addrs = '{8'h20, 8'h24, 8'h28, 8'h2c, 8'h00, 8'h1c};
    for (int j = 0; j < 3; j++) mf[j] = '0;
    @(negedge clk);
    do_reset("R9 initial");

    // R1: set burst bits; R5 read in same cycle returns old value
    cyc(1, 1, 8'h20, 32'h0000_0005, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 1, 8'h20, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R2: zeros written leave bits alone, other kinds untouched
    cyc(1, 0, 8'h24, 32'h0000_0100, 0, 0, 0, 0, 0, 0, "R1 single");
    cyc(1, 0, 8'h20, 32'h0000_0000, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 1, 8'h24, 0, 0, 0, 0, 0, 0, 0, "R2 read");
    // R3: done clears own kind only
    cyc(0, 0, 8'h00, 0, 16'h0000, 16'h0000, 16'h0105, 0, 0, 0, "R3 wrong kind");
    cyc(0, 0, 8'h00, 0, 16'h0001, 0, 0, 0, 0, 0, "R3");
    // R4: write and done collide
    cyc(1, 0, 8'h28, 32'h0000_8000, 0, 0, 16'h8000, 0, 0, 0, "R4");
    cyc(0, 1, 8'h28, 0, 0, 0, 0, 0, 0, 0, "R4 read");
    // R10: rewrite of set bit, one done clears it
    cyc(1, 0, 8'h28, 32'h0000_8000, 0, 0, 0, 0, 0, 0, "R10 rewrite");
    cyc(0, 0, 8'h00, 0, 0, 0, 16'h8000, 0, 0, 0, "R10 clear");
    cyc(0, 1, 8'h28, 0, 0, 0, 0, 0, 0, 0, "R10 read");
    // R6: upper bits ignored on write, zero on read
    cyc(1, 0, 8'h24, 32'hffff_0000, 0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 1, 8'h24, 0, 0, 0, 0, 0, 0, 0, "R6 read");
    // R7: unmapped offset
    cyc(1, 0, 8'h2c, 32'hffff_ffff, 0, 0, 0, 0, 0, 0, "R7 write");
    cyc(0, 1, 8'h2c, 0, 0, 0, 0, 0, 0, 0, "R7 read");
    cyc(0, 1, 8'h20, 0, 0, 0, 0, 0, 0, 0, "R7 burst intact");
    // R8: peripheral merge
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 16'h00f0, 16'h0f00, 16'hf000, "R8");
    idle("R8 drop");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      a = addrs[$urandom_range(0, 5)] | 8'($urandom_range(0, 3));
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom,
          16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
          16'($urandom & $urandom & $urandom),
          16'($urandom & $urandom), 16'($urandom & $urandom), 16'($urandom & $urandom),
          "R8 random");
      if (n == 1500) do_reset("R9 midrun");
    end

    summary();
    $finish;
  end
endmodule